// File: doc/BRIEF.md
# Programmable Line-to-Bayer Reformatter

This block takes one line from a sensor with an interleaved readout and turns it into one to four output lines. Each pixel is scattered into an internal line buffer. A short microprogram chooses the destination of every pixel. Each program entry names one of eight address pointers and says how that pointer moves after use. The program the block uses depends on whether the input line is even or odd. When the whole line has been written, the block plays the output lines back one after another. While it does so it holds the input off.

When the format enable is low, the block is a wire. Pixels and line markers pass straight through in the same cycle. The buffer holds `4*SEG` pixels. The output-line width is capped by the buffer share each line may use.

Top module: `line_reformatter`

## Requirements
- R1: While `fmt_en` is 0, `out_valid`, `out_data`, `out_sol` and `out_eol` equal `in_valid`, `in_data`, `in_sol` and `in_eol` in the same cycle, and `in_ready` is 1.
- R2: A program entry is 5 bits. Bits [2:0] select a pointer, and bits [4:3] give the update applied after use: 00 hold, 01 add one, 10 subtract one, 11 hold. The pixel is written at the pointer's value before the update, and a later write to the same address replaces an earlier one.
- R3: On the first pixel of every input line (`in_sol`), all eight pointers take their values from `start_addr` (pointer k at bits [k*AW +: AW]), and the pointers then continue from there.
- R4: A line whose first pixel carries `in_sof` is even. Each later line flips parity. Even lines use `prog_even` and odd lines use `prog_odd`, with entry j at bits [5j+4:5j].
- R5: Each accepted pixel uses one entry. The entry index restarts at 0 on `in_sol` and wraps to 0 after entry n, where n is the 4-bit length field of the current parity (n+1 entries).
- R6: With `lnum` = m, m+1 output lines of W pixels are produced. Output line k reads buffer addresses k*W to k*W+W-1. `out_sol` marks the first pixel of each line and `out_eol` marks the last.
- R7: Readout starts in the cycle after the pixel carrying `in_eol` is accepted and gives one pixel per cycle with no gap. `in_ready` is 0 throughout readout and returns to 1 in the cycle after the last pixel.
- R8: W is `out_width` clamped to a cap that depends on `lnum`: 4*SEG for 0, 2*SEG for 1, and SEG for 2 or 3.
- R9: A write whose address is at or above 4*SEG is dropped and leaves the buffer unchanged.
- R10: After reset with `fmt_en` at 1, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fmt_en | input | 1 | Reformatting enable; 0 gives pass-through |
| lnum | input | 2 | Output lines per input line, minus one |
| out_width | input | AW | Requested pixels per output line |
| start_addr | input | 8*AW | Start values of the eight pointers |
| prog_even | input | 80 | Sixteen 5-bit entries for even lines |
| prog_odd | input | 80 | Sixteen 5-bit entries for odd lines |
| plen_even | input | 4 | Index of the last even entry |
| plen_odd | input | 4 | Index of the last odd entry |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | PW | Input pixel |
| in_sof | input | 1 | First pixel of frame |
| in_sol | input | 1 | First pixel of line |
| in_eol | input | 1 | Last pixel of line |
| in_ready | output | 1 | Input accepted when high |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | PW | Output pixel |
| out_sol | output | 1 | First pixel of output line |
| out_eol | output | 1 | Last pixel of output line |

## Verification
The bench sends lines whose result shows a wrong pointer reload at once. If the pointers were not reloaded, the second line of a frame would land after the first one instead of on top of it. It runs a hold entry and a decrement entry that aim at the same address, so that a wrong update code or a wrong write order shows up as the wrong surviving pixel. It also runs program lengths that wrap in the middle of a line and an odd line that follows an even one, which catches a wrong wrap point or a parity that fails to flip. Out-of-range pointers and oversized widths test the drop rule and the clamp: a block that wraps such a write, or that fails to clamp, would overwrite live pixels or read past the buffer.

// File: rtl/line_reformatter.sv
module line_reformatter #(
  parameter int PW  = 10,
  parameter int SEG = 256,
  localparam int DEPTH = 4 * SEG,
  localparam int AW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH),
  localparam int EW    = 5,
  localparam int NPTR  = 8,
  localparam int NENT  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fmt_en,
  input  logic [1:0]           lnum,
  input  logic [AW-1:0]        out_width,
  input  logic [NPTR*AW-1:0]   start_addr,
  input  logic [NENT*EW-1:0]   prog_even,
  input  logic [NENT*EW-1:0]   prog_odd,
  input  logic [3:0]           plen_even,
  input  logic [3:0]           plen_odd,
  input  logic                 in_valid,
  input  logic [PW-1:0]        in_data,
  input  logic                 in_sof,
  input  logic                 in_sol,
  input  logic                 in_eol,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [PW-1:0]        out_data,
  output logic                 out_sol,
  output logic                 out_eol
);

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q [NPTR];
  logic [3:0]    idx_q;
  logic          par_q, nxt_par_q;
  logic          rd_q;
  logic [1:0]    ln_q;
  logic [AW-1:0] col_q;

  logic [AW-1:0] cap, effw, waddr, wnext, rd_addr, ln_ext;
  logic [EW-1:0] entry;
  logic [2:0]    sel;
  logic [1:0]    upd;
  logic [3:0]    cur_idx, plen_cur;
  logic          cur_par, accept, wr_ok;

  always_comb begin
    case (lnum)
      2'd0:    cap = AW'(DEPTH);
      2'd1:    cap = AW'(2 * SEG);
      default: cap = AW'(SEG);
    endcase
  end

  assign effw     = (out_width > cap) ? cap : out_width;
  assign accept   = fmt_en && !rd_q && in_valid;
  assign cur_par  = in_sol ? (in_sof ? 1'b0 : nxt_par_q) : par_q;
  assign cur_idx  = in_sol ? 4'd0 : idx_q;
  assign plen_cur = cur_par ? plen_odd : plen_even;
  assign entry    = cur_par ? prog_odd[cur_idx*EW +: EW] : prog_even[cur_idx*EW +: EW];
  assign sel      = entry[2:0];
  assign upd      = entry[4:3];
  assign waddr    = in_sol ? start_addr[sel*AW +: AW] : ptr_q[sel];
  assign wr_ok    = accept && (waddr < AW'(DEPTH));

  always_comb begin
    case (upd)
      2'b01:   wnext = waddr + 1'b1;
      2'b10:   wnext = waddr - 1'b1;
      default: wnext = waddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPTR; k++) ptr_q[k] <= '0;
      idx_q     <= '0;
      par_q     <= 1'b0;
      nxt_par_q <= 1'b0;
    end else if (accept) begin
      for (int k = 0; k < NPTR; k++)
        if (in_sol) ptr_q[k] <= start_addr[k*AW +: AW];
      ptr_q[sel] <= wnext;
      idx_q <= (cur_idx == plen_cur) ? 4'd0 : cur_idx + 4'd1;
      if (in_sol) begin
        par_q     <= cur_par;
        nxt_par_q <= ~cur_par;
      end
    end
  end

  always_ff @(posedge clk)
    if (wr_ok) mem[waddr[IW-1:0]] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      ln_q  <= '0;
      col_q <= '0;
    end else if (!fmt_en) begin
      rd_q <= 1'b0;
    end else if (!rd_q) begin
      if (accept && in_eol && effw != '0) begin
        rd_q  <= 1'b1;
        ln_q  <= '0;
        col_q <= '0;
      end
    end else if (col_q == effw - 1'b1) begin
      col_q <= '0;
      if (ln_q == lnum) rd_q <= 1'b0;
      else              ln_q <= ln_q + 2'd1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign ln_ext  = AW'(ln_q);
  assign rd_addr = ln_ext * effw + col_q;

  assign in_ready  = fmt_en ? !rd_q : 1'b1;
  assign out_valid = fmt_en ? rd_q : in_valid;
  assign out_data  = fmt_en ? mem[rd_addr[IW-1:0]] : in_data;
  assign out_sol   = fmt_en ? (rd_q && col_q == '0) : in_sol;
  assign out_eol   = fmt_en ? (rd_q && col_q == effw - 1'b1) : in_eol;

  AST_READ_FOLLOWS_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eol && effw != '0) |=> (!fmt_en || (out_valid && out_sol))); // R7

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_en && out_valid && !(out_eol && ln_q == lnum)) |=> (!fmt_en || out_valid)); // R7

  AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_en && out_valid) |-> !in_ready); // R7

  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_en && rd_q) |-> (rd_addr < AW'(DEPTH))); // R8

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sol) |=> (idx_q <= 4'd1)); // R5

endmodule

// File: tb/line_reformatter_bench.sv
module line_reformatter_bench;
  localparam int PW = 10, SEG = 8, DEPTH = 32, AW = 6;

  logic clk = 0, rst_n = 0;
  logic fmt_en = 1;
  logic [1:0] lnum = 0;
  logic [AW-1:0] out_width = 0;
  logic [8*AW-1:0] start_addr = '0;
  logic [79:0] prog_even = '0, prog_odd = '0;
  logic [3:0] plen_even = 0, plen_odd = 0;
  logic in_valid = 0, in_sof = 0, in_sol = 0, in_eol = 0;
  logic [PW-1:0] in_data = 0;
  logic in_ready, out_valid, out_sol, out_eol;
  logic [PW-1:0] out_data;

  int total = 0, bad = 0;
  logic [PW-1:0] mdl [DEPTH];
  bit next_odd = 0;

  always #4 clk = ~clk;

  line_reformatter #(.PW(PW), .SEG(SEG)) u_line_reformatter (
    .clk(clk), .rst_n(rst_n), .fmt_en(fmt_en), .lnum(lnum), .out_width(out_width),
    .start_addr(start_addr), .prog_even(prog_even), .prog_odd(prog_odd),
    .plen_even(plen_even), .plen_odd(plen_odd), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_sol(in_sol), .in_eol(in_eol), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ent(input int p, input int u);
    return {u[1:0], p[2:0]};
  endfunction

  task automatic set_start(input int k, input int v);
    start_addr[k*AW +: AW] = AW'(v);
  endtask

  function automatic int width_now();
    int cap;
    cap = (lnum == 0) ? 4*SEG : (lnum == 1) ? 2*SEG : SEG;
    return (int'(out_width) > cap) ? cap : int'(out_width);
  endfunction

  task automatic run_line(input int n, input int base, input bit sof, input string tag);
    bit odd;
    int p [8];
    int idx, w;
    logic [4:0] e;
    odd = sof ? 1'b0 : next_odd;
    next_odd = ~odd;
    for (int k = 0; k < 8; k++) p[k] = int'(start_addr[k*AW +: AW]);
    idx = 0;
    for (int i = 0; i < n; i++) begin
      e = odd ? prog_odd[idx*5 +: 5] : prog_even[idx*5 +: 5];
      if (p[e[2:0]] < DEPTH) mdl[p[e[2:0]]] = PW'(base + i);
      if (e[4:3] == 2'b01) p[e[2:0]] = (p[e[2:0]] + 1) & 63;
      else if (e[4:3] == 2'b10) p[e[2:0]] = (p[e[2:0]] + 63) & 63;
      idx = (idx == int'(odd ? plen_odd : plen_even)) ? 0 : idx + 1;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, {tag, " R7 ready during write"}, int'(in_ready), 1);
      in_valid = 1; in_data = PW'(base + i);
      in_sol = (i == 0); in_eol = (i == n - 1); in_sof = sof && (i == 0);
    end
    w = width_now();
    for (int l = 0; l <= int'(lnum); l++)
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        in_valid = 0; in_sol = 0; in_eol = 0; in_sof = 0;
        chk(out_valid && !in_ready && out_data === mdl[l*w + c] &&
            out_sol == (c == 0) && out_eol == (c == w - 1),
            {tag, " R6 readout pixel"}, int'(out_data), int'(mdl[l*w + c]));
      end
    @(negedge clk);
    chk(in_ready && !out_valid, {tag, " R7 readout ends"}, int'({in_ready, out_valid}), 2);
  endtask

  task automatic t_reset();
    chk(!out_valid && in_ready, "R10 reset state", int'({out_valid, in_ready}), 1);
  endtask

  task automatic t_pass();
    fmt_en = 0;
    @(negedge clk);
    in_valid = 1; in_data = 10'h155; in_sol = 1; in_eol = 0;
    #1 chk(out_valid && out_data == 10'h155 && out_sol && !out_eol && in_ready,
           "R1 pass-through a", int'(out_data), 'h155);
    @(negedge clk);
    in_valid = 0; in_data = 10'h2AA; in_sol = 0; in_eol = 1;
    #1 chk(!out_valid && out_data == 10'h2AA && !out_sol && out_eol && in_ready,
           "R1 pass-through b", int'(out_data), 'h2AA);
    @(negedge clk);
    in_eol = 0; fmt_en = 1;
  endtask

  task automatic t_fill();
    lnum = 0; out_width = 32;
    set_start(0, 0);
    prog_even[4:0] = ent(0, 1); plen_even = 0;
    prog_odd[4:0] = ent(0, 1); plen_odd = 0;
    run_line(32, 100, 1, "fill R2");
  endtask

  task automatic t_split();
    lnum = 1; out_width = 4;
    set_start(0, 0); set_start(1, 4);
    prog_even[9:0] = {ent(1, 1), ent(0, 1)}; plen_even = 1;
    run_line(8, 200, 1, "split R5");
  endtask

  task automatic t_parity();
    prog_odd[9:0] = {ent(0, 1), ent(1, 1)}; plen_odd = 1;
    run_line(8, 300, 0, "odd line R4 R3");
    run_line(8, 400, 0, "even again R4 R3");
    run_line(8, 500, 0, "odd again R4");
    run_line(8, 600, 1, "sof forces even R4");
  endtask

  task automatic t_dec_hold();
    lnum = 0; out_width = 8;
    set_start(2, 7);
    prog_even[4:0] = ent(2, 2); plen_even = 0;
    run_line(8, 700, 1, "decrement R2");
    set_start(3, 5);
    prog_even[9:0] = {ent(2, 2), ent(3, 0)}; plen_even = 1;
    run_line(6, 800, 1, "hold and overwrite R2");
    prog_even[9:0] = {ent(2, 3), ent(3, 3)};
    run_line(4, 850, 1, "code 11 holds R2");
  endtask

  task automatic t_wrap();
    lnum = 0; out_width = 32;
    set_start(0, 0); set_start(1, 10); set_start(2, 20);
    prog_even[14:0] = {ent(2, 1), ent(1, 1), ent(0, 1)}; plen_even = 2;
    run_line(9, 900, 1, "index wrap R5");
    run_line(9, 950, 1, "reload on next line R3");
  endtask

  task automatic t_clamp();
    set_start(0, 0);
    prog_even[4:0] = ent(0, 1); plen_even = 0;
    lnum = 2; out_width = 20;
    run_line(4, 1000 - 24, 1, "three lines clamp R8");
    lnum = 0; out_width = 40;
    run_line(4, 1000 - 48, 1, "one line clamp R8");
    lnum = 1; out_width = 63;
    run_line(4, 1000 - 80, 1, "two lines clamp R8");
    lnum = 3; out_width = 3;
    run_line(4, 1000 - 100, 1, "four short lines R6");
  endtask

  task automatic t_range();
    lnum = 0; out_width = 32;
    prog_even[4:0] = ent(0, 1); plen_even = 0;
    set_start(0, 40);
    run_line(5, 1000 - 120, 1, "all dropped R9");
    set_start(0, 30);
    run_line(4, 1000 - 140, 1, "partly dropped R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_fill();
    t_split();
    t_parity();
    t_dec_hold();
    t_wrap();
    t_clamp();
    t_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule